// File: doc/BRIEF.md
# SEC-DED Memory Word Protector

This block protects 64-bit memory words with an 8-bit single-error-correcting, double-error-detecting code. On the write side it turns each word into a set of check bits, which are stored next to the data. On the read side it takes the word and the check bits that come back from memory. It recomputes the code and forms a syndrome. It then repairs any one flipped bit, or flags the word as unrepairable when two bits have flipped.

Protection is applied per access. Each write or read carries a flag that says whether its target region is protected. A mode input says whether the bus runs 64 bits wide. The code is used only when both are true. In every other case the data passes straight through, the check output is zero, and no error is raised.

The syndrome of the first detected error is kept in a diagnostic register. Two sticky status bits sit beside it, one for corrected errors and one for uncorrectable errors. Software clears each status bit with a one-cycle clear pulse.

Top module: `ecc_unit`

## Requirements
- R1: One cycle after a write with protection active, `wr_valid_o` is high and `wr_chk_o` holds the code for the word. Data bits take the codeword positions 1..71 that are not powers of two, in ascending order, so data bit 0 sits at position 3. For k in 0..6, check bit k is the XOR of the data bits whose position has bit k set. Check bit 7 is the XOR of all 64 data bits and check bits 0..6.
- R2: A protected read whose check bits match the data returns the same data one cycle later, with `rd_sec_o` and `rd_ded_o` low. The status registers are left unchanged.
- R3: A protected read with exactly one data bit flipped returns the original data and raises `rd_sec_o`.
- R4: A protected read with exactly one check bit flipped returns the data unchanged and raises `rd_sec_o`.
- R5: A protected read with two flipped bits raises `rd_ded_o`, leaves `rd_sec_o` low, and returns the received data uncorrected.
- R6: The syndrome is the 8-bit XOR of the check bits recomputed from the received data and the check bits received. When an error is detected while both sticky bits are clear, the syndrome is stored in `stat_syn_o`, and `stat_sec_o` or `stat_ded_o` is set one cycle after the read.
- R7: While either sticky bit is set, later errors do not change `stat_syn_o`. A later error still sets its own sticky bit.
- R8: A one-cycle pulse on `clr_sec` clears `stat_sec_o`, and a pulse on `clr_ded` clears `stat_ded_o`. Once both are clear, the next error captures its own syndrome.
- R9: When the access is not flagged as protected, a write gives `wr_chk_o` = 0, and a read returns the raw data with no flags and no status change.
- R10: When `bus64` is low, the behaviour is the same as in R9, whatever the protection flag says.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus64 | input | 1 | High when the bus runs 64 bits wide |
| wr_valid | input | 1 | Write word present |
| wr_prot | input | 1 | Write targets a protected region |
| wr_data | input | 64 | Word to be written |
| rd_valid | input | 1 | Read word present |
| rd_prot | input | 1 | Read targets a protected region |
| rd_data | input | 64 | Word returned from memory |
| rd_chk | input | 8 | Check bits returned from memory |
| clr_sec | input | 1 | Clear pulse for the corrected-error status |
| clr_ded | input | 1 | Clear pulse for the uncorrectable-error status |
| wr_valid_o | output | 1 | Check bits valid |
| wr_chk_o | output | 8 | Check bits to store with the word |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 64 | Corrected or passed-through word |
| rd_sec_o | output | 1 | Single error corrected on this read |
| rd_ded_o | output | 1 | Double error detected on this read |
| stat_syn_o | output | 8 | Syndrome of the first captured error |
| stat_sec_o | output | 1 | Sticky corrected-error status |
| stat_ded_o | output | 1 | Sticky uncorrectable-error status |

## Verification
The assertions assume that a read word carries at most two flipped bits. Three or more flips can alias to a single-error syndrome, and that case is outside the contract. The stimulus never injects more than two flips into a protected read; unprotected and 32-bit reads carry arbitrary corruption. The assertions also assume that clear pulses arrive only while no read is in flight. The bench waits for the pipeline to drain before pulsing a clear, so the status checks never race a new error.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  // number of Hamming check bits needed for dw data bits
  function automatic int ham_bits(input int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  // codeword position of data bit i: non-powers of two, ascending
  function automatic int data_pos(input int i);
    int p;
    int n;
    p = 0;
    n = 0;
    for (int q = 3; q < 4096; q++) begin
      if ((q & (q - 1)) != 0) begin
        if (n == i && p == 0) p = q;
        n++;
      end
    end
    return p;
  endfunction

endpackage

// File: rtl/ecc_encode.sv
module ecc_encode #(
  parameter int DATA_W = 64,
  parameter int HAM_W  = 7
) (
  input  logic [DATA_W-1:0] data,
  output logic [HAM_W:0]    chk
);
  logic [HAM_W-1:0] pos_tab [DATA_W];
  logic [HAM_W-1:0] acc;

  for (genvar g = 0; g < DATA_W; g++) begin : g_pos
    localparam int P = ecc_pkg::data_pos(g);
    assign pos_tab[g] = HAM_W'(P);
  end

  // XOR of the positions of all set data bits gives the Hamming bits
  always_comb begin
    acc = '0;
    for (int i = 0; i < DATA_W; i++)
      acc = acc ^ (pos_tab[i] & {HAM_W{data[i]}});
  end

  assign chk = {(^data) ^ (^acc), acc};
endmodule

// File: rtl/ecc_decode.sv
module ecc_decode #(
  parameter int DATA_W = 64,
  parameter int HAM_W  = 7
) (
  input  logic [DATA_W-1:0] data,
  input  logic [HAM_W:0]    chk_in,
  output logic [HAM_W:0]    syn,
  output logic [DATA_W-1:0] data_fix,
  output logic              sec,
  output logic              ded
);
  logic [HAM_W:0]    calc;
  logic [DATA_W-1:0] flip;
  logic              any_err;
  logic              odd;

  ecc_encode #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_enc (
    .data (data),
    .chk  (calc)
  );

  assign syn     = calc ^ chk_in;
  assign any_err = |syn;
  assign odd     = ^syn;   // overall parity error of the received word
  assign sec     = any_err & odd;
  assign ded     = any_err & ~odd;

  for (genvar g = 0; g < DATA_W; g++) begin : g_fix
    localparam int P = ecc_pkg::data_pos(g);
    assign flip[g] = sec && (syn[HAM_W-1:0] == HAM_W'(P));
  end

  assign data_fix = data ^ flip;
endmodule

// File: rtl/ecc_status.sv
module ecc_status #(
  parameter int CHK_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_sec,
  input  logic             evt_ded,
  input  logic [CHK_W-1:0] evt_syn,
  input  logic             clr_sec,
  input  logic             clr_ded,
  output logic [CHK_W-1:0] syn_q,
  output logic             sec_q,
  output logic             ded_q
);
  logic armed;
  assign armed = !sec_q && !ded_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      syn_q <= '0;
      sec_q <= 1'b0;
      ded_q <= 1'b0;
    end else begin
      if (armed && (evt_sec || evt_ded)) syn_q <= evt_syn;
      if (evt_sec)      sec_q <= 1'b1;
      else if (clr_sec) sec_q <= 1'b0;
      if (evt_ded)      ded_q <= 1'b1;
      else if (clr_ded) ded_q <= 1'b0;
    end
  end

  // R7
  syn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sec_q || ded_q) |=> $stable(syn_q));

  // R8
  sec_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_sec && !evt_sec) |=> !sec_q);

  // R8
  ded_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_ded && !evt_ded) |=> !ded_q);
endmodule

// File: rtl/ecc_unit.sv
module ecc_unit #(
  parameter  int DATA_W = 64,
  localparam int HAM_W  = ecc_pkg::ham_bits(DATA_W),
  localparam int CHK_W  = HAM_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus64,
  input  logic              wr_valid,
  input  logic              wr_prot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  input  logic              rd_prot,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [CHK_W-1:0]  rd_chk,
  input  logic              clr_sec,
  input  logic              clr_ded,
  output logic              wr_valid_o,
  output logic [CHK_W-1:0]  wr_chk_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_sec_o,
  output logic              rd_ded_o,
  output logic [CHK_W-1:0]  stat_syn_o,
  output logic              stat_sec_o,
  output logic              stat_ded_o
);
  logic [CHK_W-1:0]  enc_chk;
  logic [CHK_W-1:0]  dec_syn;
  logic [DATA_W-1:0] dec_data;
  logic              dec_sec;
  logic              dec_ded;
  logic              wr_on;
  logic              rd_on;
  logic              evt_sec;
  logic              evt_ded;

  assign wr_on = bus64 && wr_prot;
  assign rd_on = bus64 && rd_prot;

  ecc_encode #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_wr_enc (
    .data (wr_data),
    .chk  (enc_chk)
  );

  ecc_decode #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_rd_dec (
    .data     (rd_data),
    .chk_in   (rd_chk),
    .syn      (dec_syn),
    .data_fix (dec_data),
    .sec      (dec_sec),
    .ded      (dec_ded)
  );

  assign evt_sec = rd_valid && rd_on && dec_sec;
  assign evt_ded = rd_valid && rd_on && dec_ded;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid_o <= 1'b0;
      wr_chk_o   <= '0;
    end else begin
      wr_valid_o <= wr_valid;
      if (wr_valid) wr_chk_o <= wr_on ? enc_chk : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      rd_sec_o   <= 1'b0;
      rd_ded_o   <= 1'b0;
    end else begin
      rd_valid_o <= rd_valid;
      rd_sec_o   <= evt_sec;
      rd_ded_o   <= evt_ded;
      if (rd_valid) rd_data_o <= rd_on ? dec_data : rd_data;
    end
  end

  ecc_status #(.CHK_W(CHK_W)) u_status (
    .clk     (clk),
    .rst     (rst),
    .evt_sec (evt_sec),
    .evt_ded (evt_ded),
    .evt_syn (dec_syn),
    .clr_sec (clr_sec),
    .clr_ded (clr_ded),
    .syn_q   (stat_syn_o),
    .sec_q   (stat_sec_o),
    .ded_q   (stat_ded_o)
  );

  // R9
  bypass_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_prot) |=> (!rd_sec_o && !rd_ded_o && rd_data_o == $past(rd_data)));

  // R10
  bypass_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !bus64) |=> (wr_chk_o == '0));

  // R6
  syn_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_sec_o || stat_ded_o) |-> (stat_syn_o != '0));

  // R5
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_sec_o && rd_ded_o));
endmodule

// File: tb/ecc_unit_bench.sv
module ecc_unit_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, bus64, wr_valid, wr_prot, rd_valid, rd_prot, clr_sec, clr_ded;
  logic [63:0] wr_data, rd_data, rd_data_o;
  logic [7:0]  rd_chk, wr_chk_o, stat_syn_o;
  logic        wr_valid_o, rd_valid_o, rd_sec_o, rd_ded_o, stat_sec_o, stat_ded_o;

  ecc_unit u_ecc_unit (
    .clk(clk), .rst(rst), .bus64(bus64),
    .wr_valid(wr_valid), .wr_prot(wr_prot), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_prot(rd_prot), .rd_data(rd_data), .rd_chk(rd_chk),
    .clr_sec(clr_sec), .clr_ded(clr_ded),
    .wr_valid_o(wr_valid_o), .wr_chk_o(wr_chk_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .rd_sec_o(rd_sec_o), .rd_ded_o(rd_ded_o),
    .stat_syn_o(stat_syn_o), .stat_sec_o(stat_sec_o), .stat_ded_o(stat_ded_o)
  );

  typedef struct {
    bit          is_wr;
    logic [63:0] d;
    logic [7:0]  c;
    logic        sec;
    logic        ded;
    string       req;
  } item_t;

  item_t sb[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // code from R1: walk positions, skip powers of two
  function automatic logic [7:0] ref_chk(input logic [63:0] d);
    logic [7:0] c;
    int p;
    c = '0;
    p = 1;
    for (int i = 0; i < 64; i++) begin
      while ((p & (p - 1)) == 0) p++;
      for (int k = 0; k < 7; k++)
        if (((p >> k) & 1) == 1) c[k] = c[k] ^ d[i];
      p++;
    end
    c[7] = (^d) ^ (^c[6:0]);
    return c;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [63:0] d, input logic prot, input string req);
    item_t it;
    @(negedge clk);
    wr_valid = 1'b1; wr_prot = prot; wr_data = d;
    it.is_wr = 1'b1; it.d = '0;
    it.c = (prot && bus64) ? ref_chk(d) : 8'h00;
    it.sec = 1'b0; it.ded = 1'b0; it.req = req;
    sb.push_back(it);
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic do_read(input logic [63:0] d, input logic [7:0] c, input logic prot,
                         input logic [63:0] exp_d, input logic exp_sec,
                         input logic exp_ded, input string req);
    item_t it;
    @(negedge clk);
    rd_valid = 1'b1; rd_prot = prot; rd_data = d; rd_chk = c;
    it.is_wr = 1'b0; it.d = exp_d; it.c = '0;
    it.sec = exp_sec; it.ded = exp_ded; it.req = req;
    sb.push_back(it);
    @(posedge clk); #1;
    rd_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_clr(input bit s, input bit dd);
    @(negedge clk);
    clr_sec = s; clr_ded = dd;
    @(negedge clk);
    clr_sec = 1'b0; clr_ded = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_stat(input string req, input logic [7:0] syn,
                            input logic sec, input logic ded);
    check({req, " syndrome"}, 64'(stat_syn_o), 64'(syn));
    check({req, " sec status"}, 64'(stat_sec_o), 64'(sec));
    check({req, " ded status"}, 64'(stat_ded_o), 64'(ded));
  endtask

  // monitor: pops scoreboard as results appear
  always @(negedge clk) begin
    if (!rst && (wr_valid_o || rd_valid_o)) begin
      if (sb.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL scoreboard unexpected output actual=1 expected=0");
      end else begin
        item_t it;
        it = sb.pop_front();
        if (it.is_wr) begin
          check({it.req, " check bits"}, 64'(wr_chk_o), 64'(it.c));
        end else begin
          check({it.req, " data"}, rd_data_o, it.d);
          check({it.req, " sec flag"}, 64'(rd_sec_o), 64'(it.sec));
          check({it.req, " ded flag"}, 64'(rd_ded_o), 64'(it.ded));
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] pat [8];
    logic [63:0] d, e;
    logic [7:0]  c, syn1, syn2;
    rst = 1'b1; bus64 = 1'b1; wr_valid = 0; wr_prot = 0; rd_valid = 0; rd_prot = 0;
    wr_data = '0; rd_data = '0; rd_chk = '0; clr_sec = 0; clr_ded = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 wr_chk_o", 64'(wr_chk_o), 64'h0);
    check("R11 rd_data_o", rd_data_o, 64'h0);
    check("R11 flags", 64'({wr_valid_o, rd_valid_o, rd_sec_o, rd_ded_o}), 64'h0);
    check_stat("R11", 8'h00, 1'b0, 1'b0);

    pat[0] = 64'h0; pat[1] = '1; pat[2] = 64'h0123456789ABCDEF; pat[3] = 64'h8000000000000001;
    pat[4] = 64'hDEADBEEFCAFEF00D; pat[5] = 64'h5555AAAA5555AAAA;
    pat[6] = 64'h0000000100000000; pat[7] = 64'hFEDCBA9876543210;

    // R1 write encoding over several patterns
    foreach (pat[i]) do_write(pat[i], 1'b1, "R1");
    // R2 clean reads
    foreach (pat[i]) do_read(pat[i], ref_chk(pat[i]), 1'b1, pat[i], 1'b0, 1'b0, "R2");
    drain();
    check_stat("R2", 8'h00, 1'b0, 1'b0);

    // R3 single data error, first capture R6
    d = pat[2]; c = ref_chk(d); e = d ^ 64'h1;
    syn1 = ref_chk(e) ^ c;
    do_read(e, c, 1'b1, d, 1'b1, 1'b0, "R3 bit0");
    drain();
    check_stat("R6 first capture", syn1, 1'b1, 1'b0);
    d = pat[3]; e = d ^ 64'h8000000000000000;
    do_read(e, ref_chk(d), 1'b1, d, 1'b1, 1'b0, "R3 bit63");
    d = pat[4]; e = d ^ (64'h1 << 30);
    do_read(e, ref_chk(d), 1'b1, d, 1'b1, 1'b0, "R3 bit30");
    // R4 check-bit errors
    d = pat[2];
    do_read(d, ref_chk(d) ^ 8'h80, 1'b1, d, 1'b1, 1'b0, "R4 chk7");
    do_read(d, ref_chk(d) ^ 8'h04, 1'b1, d, 1'b1, 1'b0, "R4 chk2");
    // R5 double error
    e = d ^ (64'h1 << 5) ^ (64'h1 << 40);
    do_read(e, ref_chk(d), 1'b1, e, 1'b0, 1'b1, "R5 data pair");
    do_read(d, ref_chk(d) ^ 8'h81, 1'b1, d, 1'b0, 1'b1, "R5 check pair");
    drain();
    check_stat("R7 held", syn1, 1'b1, 1'b1);

    // R8 clears
    pulse_clr(1'b1, 1'b0);
    check_stat("R8 sec cleared", syn1, 1'b0, 1'b1);
    pulse_clr(1'b0, 1'b1);
    check_stat("R8 ded cleared", syn1, 1'b0, 1'b0);
    d = pat[1]; c = ref_chk(d); e = d ^ 64'h6;
    syn2 = ref_chk(e) ^ c;
    do_read(e, c, 1'b1, e, 1'b0, 1'b1, "R8 rearm read");
    drain();
    check_stat("R8 rearm capture", syn2, 1'b0, 1'b1);
    pulse_clr(1'b1, 1'b1);
    check_stat("R8 all clear", syn2, 1'b0, 1'b0);

    // R9 unprotected region
    do_write(pat[2], 1'b0, "R9 write");
    e = pat[2] ^ 64'h8;
    do_read(e, 8'h5A, 1'b0, e, 1'b0, 1'b0, "R9 read");
    drain();
    check_stat("R9 status", syn2, 1'b0, 1'b0);

    // R10 32-bit mode
    bus64 = 1'b0;
    do_write(pat[4], 1'b1, "R10 write");
    e = pat[4] ^ 64'h30;
    do_read(e, ref_chk(pat[4]), 1'b1, e, 1'b0, 1'b0, "R10 read");
    drain();
    check_stat("R10 status", syn2, 1'b0, 1'b0);
    bus64 = 1'b1;

    check("scoreboard drained", 64'(sb.size()), 64'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule